// File: doc/BRIEF.md
# Dual FIFO Control and Trigger Unit

This block sits between a two-wire serial controller, which has separate master and slave engines, and the rest of the chip. It contains two byte FIFOs, eight entries each: a transmit FIFO that the host fills and an engine drains, and a receive FIFO that an engine fills and the host drains. A single 32-bit control word, written and read over a plain register port with no address, picks which engine each FIFO is connected to. It also sets a fill-level threshold for each direction, enables a DMA request line for each direction, and flushes either FIFO on request.

Each direction compares its fill count with its threshold and drives a trigger. A DMA request is that trigger qualified by the direction's enable bit. The receive request is additionally held low while the receive FIFO is empty, so a threshold of zero never asks for a read from an empty FIFO. A flush bit reads back as 1 for exactly one cycle and then clears itself, and the FIFO is empty from that point on.

Top module: `dual_fifo_ctrl`

## Requirements
- R1: After reset the control word reads 0x00040004. The reserved bits (28:19, 12:3) always read 0, and writes to them have no effect.
- R2: Control word fields are placed as follows: bit 31 receive assignment, bit 30 receive flush, bit 29 receive DMA enable, bits 18:16 receive threshold, bit 15 transmit assignment, bit 14 transmit flush, bit 13 transmit DMA enable, bits 2:0 transmit threshold. Written values of the non-flush fields read back unchanged.
- R3: A flush bit written as 1 reads 1 in the cycle after the write and reads 0 in the cycle after that, unless it is written again.
- R4: A flush takes one cycle and leaves the FIFO with count 0 and empty set. A push or pop presented in that flush cycle is dropped. The other FIFO is not affected.
- R5: An assignment bit of 0 connects its FIFO to the master engine and 1 connects it to the slave engine. A push or pop from the engine that is not assigned is ignored. Changing the assignment keeps the stored bytes and their order.
- R6: Each FIFO holds 8 bytes in first-in first-out order, with a count from 0 to 8 and full and empty flags. A push to a full FIFO is ignored, and so is a pop from an empty FIFO. The head byte is visible on the read data output before it is popped.
- R7: The receive trigger is 1 exactly when the receive count is greater than or equal to the receive threshold, for thresholds 0 to 7.
- R8: The transmit trigger is 1 exactly when the transmit count is less than or equal to the transmit threshold.
- R9: Each DMA request equals its enable AND its trigger, and the receive request is additionally 0 while the receive FIFO is empty. A request follows a count change in the same cycle the new count appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| tx_push | input | 1 | Host push into transmit FIFO |
| tx_wdata | input | 8 | Host byte for transmit FIFO |
| tx_head | output | 8 | Transmit FIFO head byte, seen by both engines |
| m_tx_pop | input | 1 | Master engine pops transmit FIFO |
| s_tx_pop | input | 1 | Slave engine pops transmit FIFO |
| m_rx_push | input | 1 | Master engine pushes receive FIFO |
| m_rx_data | input | 8 | Master engine receive byte |
| s_rx_push | input | 1 | Slave engine pushes receive FIFO |
| s_rx_data | input | 8 | Slave engine receive byte |
| rx_pop | input | 1 | Host pop from receive FIFO |
| rx_rdata | output | 8 | Receive FIFO head byte |
| tx_count | output | 4 | Transmit fill count |
| rx_count | output | 4 | Receive fill count |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_trig | output | 1 | Transmit fill-level trigger |
| rx_trig | output | 1 | Receive fill-level trigger |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The self-clear property assumes the flush bit is not rewritten in the cycle right after it was set. The overflow property assumes a push to a full FIFO is not paired with a pop in the same cycle. The stimulus drives every push, pop and register write on its own, never two in one cycle, so both assumptions hold throughout. The threshold sweeps pass through every count from 0 to 8 in both directions only by single legal pushes, and under-run and over-run are tried only as separate single operations.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    localparam int unsigned THR_W  = 3;
    localparam int unsigned WORD_W = 32;

    localparam int unsigned B_RX_ASG = 31;
    localparam int unsigned B_RX_FL  = 30;
    localparam int unsigned B_RX_DMA = 29;
    localparam int unsigned B_RX_THR = 16;
    localparam int unsigned B_TX_ASG = 15;
    localparam int unsigned B_TX_FL  = 14;
    localparam int unsigned B_TX_DMA = 13;
    localparam int unsigned B_TX_THR = 0;

    localparam logic [WORD_W-1:0] FIELD_MASK = 32'hE007_E007;
    localparam logic [THR_W-1:0]  THR_RESET  = 3'd4;

    typedef struct packed {
        logic             rx_asg;
        logic             rx_flush;
        logic             rx_dma;
        logic [THR_W-1:0] rx_thr;
        logic             tx_asg;
        logic             tx_flush;
        logic             tx_dma;
        logic [THR_W-1:0] tx_thr;
    } ctl_t;
endpackage

// File: rtl/dfc_regs.sv
module dfc_regs
    import dfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output ctl_t              ctl,
    output logic [WORD_W-1:0] rdata
);
    ctl_t ctl_d, ctl_q;
    logic unused_rsv;

    assign unused_rsv = ^(wdata & ~FIELD_MASK);

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.rx_flush = 1'b0;
        ctl_d.tx_flush = 1'b0;
        if (we) begin
            ctl_d.rx_asg   = wdata[B_RX_ASG];
            ctl_d.rx_flush = wdata[B_RX_FL];
            ctl_d.rx_dma   = wdata[B_RX_DMA];
            ctl_d.rx_thr   = wdata[B_RX_THR +: THR_W];
            ctl_d.tx_asg   = wdata[B_TX_ASG];
            ctl_d.tx_flush = wdata[B_TX_FL];
            ctl_d.tx_dma   = wdata[B_TX_DMA];
            ctl_d.tx_thr   = wdata[B_TX_THR +: THR_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q        <= '0;
            ctl_q.rx_thr <= THR_RESET;
            ctl_q.tx_thr <= THR_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rdata                        = '0;
        rdata[B_RX_ASG]              = ctl_q.rx_asg;
        rdata[B_RX_FL]               = ctl_q.rx_flush;
        rdata[B_RX_DMA]              = ctl_q.rx_dma;
        rdata[B_RX_THR +: THR_W]     = ctl_q.rx_thr;
        rdata[B_TX_ASG]              = ctl_q.tx_asg;
        rdata[B_TX_FL]               = ctl_q.tx_flush;
        rdata[B_TX_DMA]              = ctl_q.tx_dma;
        rdata[B_TX_THR +: THR_W]     = ctl_q.tx_thr;
    end

    assign ctl = ctl_q;

    // R3: a flush bit lasts one cycle unless rewritten
    assert_rx_flush_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.rx_flush && !we) |=> !ctl_q.rx_flush);
    assert_tx_flush_self_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.tx_flush && !we) |=> !ctl_q.tx_flush);
endmodule

// File: rtl/dfc_fifo.sv
module dfc_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } fst_t;

    fst_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && !flush && (st_q.cnt != CNT_W'(DEPTH));
        pop_ok  = pop  && !flush && (st_q.cnt != '0);
        if (flush) begin
            st_d = '0;
        end else begin
            if (push_ok) st_d.wr = inc_ptr(st_q.wr);
            if (pop_ok)  st_d.rd = inc_ptr(st_q.rd);
            case ({push_ok, pop_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= wdata;
    end

    assign rdata = mem_q[st_q.rd];
    assign count = st_q.cnt;
    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);

    // R4: a flush leaves the FIFO empty on the next cycle
    assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));
    // R6: a push on a full FIFO without a pop leaves it full
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);
    // R6: a pop on an empty FIFO without a push leaves it empty
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/dfc_trig.sv
module dfc_trig #(
    parameter bit          IS_RX = 1'b0,
    parameter int unsigned CNT_W = 4,
    parameter int unsigned THR_W = 3
) (
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    input  logic             dma_en,
    input  logic             empty,
    input  logic             full,
    output logic             trig,
    output logic             req
);
    localparam int unsigned CW = (CNT_W > THR_W) ? CNT_W : THR_W;
    logic [CW-1:0] cnt_x, thr_x;

    assign cnt_x = CW'(count);
    assign thr_x = CW'(thr);

    generate
        if (IS_RX) begin : g_rx
            logic unused_full;
            assign unused_full = full;
            assign trig = (cnt_x >= thr_x);
            assign req  = dma_en && trig && !empty;
        end else begin : g_tx
            logic unused_empty;
            assign unused_empty = empty;
            assign trig = (cnt_x <= thr_x);
            assign req  = dma_en && trig && !full;
        end
    endgenerate
endmodule

// File: rtl/dual_fifo_ctrl.sv
module dual_fifo_ctrl
    import dfc_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_push,
    input  logic [DW-1:0]     tx_wdata,
    output logic [DW-1:0]     tx_head,
    input  logic              m_tx_pop,
    input  logic              s_tx_pop,
    input  logic              m_rx_push,
    input  logic [DW-1:0]     m_rx_data,
    input  logic              s_rx_push,
    input  logic [DW-1:0]     s_rx_data,
    input  logic              rx_pop,
    output logic [DW-1:0]     rx_rdata,
    output logic [CNT_W-1:0]  tx_count,
    output logic [CNT_W-1:0]  rx_count,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              tx_trig,
    output logic              rx_trig,
    output logic              tx_dma_req,
    output logic              rx_dma_req
);
    ctl_t ctl;
    logic eng_tx_pop, eng_rx_push;
    logic [DW-1:0] eng_rx_data;

    dfc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata),
        .ctl   (ctl),
        .rdata (reg_rdata)
    );

    assign eng_tx_pop  = ctl.tx_asg ? s_tx_pop  : m_tx_pop;
    assign eng_rx_push = ctl.rx_asg ? s_rx_push : m_rx_push;
    assign eng_rx_data = ctl.rx_asg ? s_rx_data : m_rx_data;

    dfc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctl.tx_flush),
        .push  (tx_push),
        .wdata (tx_wdata),
        .pop   (eng_tx_pop),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    dfc_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (ctl.rx_flush),
        .push  (eng_rx_push),
        .wdata (eng_rx_data),
        .pop   (rx_pop),
        .rdata (rx_rdata),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    dfc_trig #(.IS_RX(1'b0), .CNT_W(CNT_W), .THR_W(THR_W)) u_tx_trig (
        .count  (tx_count),
        .thr    (ctl.tx_thr),
        .dma_en (ctl.tx_dma),
        .empty  (tx_empty),
        .full   (tx_full),
        .trig   (tx_trig),
        .req    (tx_dma_req)
    );

    dfc_trig #(.IS_RX(1'b1), .CNT_W(CNT_W), .THR_W(THR_W)) u_rx_trig (
        .count  (rx_count),
        .thr    (ctl.rx_thr),
        .dma_en (ctl.rx_dma),
        .empty  (rx_empty),
        .full   (rx_full),
        .trig   (rx_trig),
        .req    (rx_dma_req)
    );

    // R1: reserved bits never read as 1
    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~FIELD_MASK) == '0);
    // R9: a disabled channel never requests
    assert_rx_dma_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.rx_dma |-> !rx_dma_req);
    assert_tx_dma_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.tx_dma |-> !tx_dma_req);
    // R9: no receive request from an empty FIFO
    assert_rx_req_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> !rx_empty);
    // R5: a push from the unassigned engine alone leaves the count unchanged
    assert_unassigned_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.rx_asg && s_rx_push && !m_rx_push && !rx_pop && !ctl.rx_flush)
        |=> $stable(rx_count));
endmodule

// File: tb/dual_fifo_ctrl_tb.sv
`timescale 1ns/1ps
module dual_fifo_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_wdata = '0;
    logic [7:0]  tx_head;
    logic        m_tx_pop = 1'b0, s_tx_pop = 1'b0;
    logic        m_rx_push = 1'b0, s_rx_push = 1'b0;
    logic [7:0]  m_rx_data = '0, s_rx_data = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_rdata;
    logic [3:0]  tx_count, rx_count;
    logic        tx_full, tx_empty, rx_full, rx_empty;
    logic        tx_trig, rx_trig, tx_dma_req, rx_dma_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dual_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_head(tx_head), .m_tx_pop(m_tx_pop), .s_tx_pop(s_tx_pop),
        .m_rx_push(m_rx_push), .m_rx_data(m_rx_data), .s_rx_push(s_rx_push),
        .s_rx_data(s_rx_data), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .tx_count(tx_count), .rx_count(rx_count), .tx_full(tx_full),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit ra, input bit rf, input bit rd, input int rt,
                                      input bit ta, input bit tf, input bit td, input int tt);
        logic [31:0] v = '0;
        v[31] = ra; v[30] = rf; v[29] = rd; v[18:16] = rt[2:0];
        v[15] = ta; v[14] = tf; v[13] = td; v[2:0] = tt[2:0];
        return v;
    endfunction

    task automatic wr(input logic [31:0] v);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic host_push(input logic [7:0] b);
        tx_push = 1'b1; tx_wdata = b;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic m_push(input logic [7:0] b);
        m_rx_push = 1'b1; m_rx_data = b;
        @(negedge clk);
        m_rx_push = 1'b0;
    endtask

    task automatic s_push(input logic [7:0] b);
        s_rx_push = 1'b1; s_rx_data = b;
        @(negedge clk);
        s_rx_push = 1'b0;
    endtask

    task automatic host_pop();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic tx_pop_eng(input bit slave);
        if (slave) s_tx_pop = 1'b1; else m_tx_pop = 1'b1;
        @(negedge clk);
        s_tx_pop = 1'b0; m_tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset value and R6/R7/R8/R9 idle outputs
        chk("R1 reset word", reg_rdata, 32'h0004_0004);
        chk("R6 reset counts", {tx_count, rx_count}, 8'h00);
        chk("R6 reset flags", {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
        chk("R8 reset tx trig", tx_trig, 1);
        chk("R7 reset rx trig", rx_trig, 0);
        chk("R9 reset reqs", {tx_dma_req, rx_dma_req}, 2'b00);

        // R7 R9: receive sweep over every level and threshold
        for (int lvl = 0; lvl <= 8; lvl++) begin
            for (int t = 0; t < 8; t++) begin
                wr(mk(0, 0, 1, t, 0, 0, 0, 4));
                chk($sformatf("R7 rx trig lvl=%0d thr=%0d", lvl, t), rx_trig, (lvl >= t));
                chk($sformatf("R9 rx req lvl=%0d thr=%0d", lvl, t), rx_dma_req,
                    (lvl >= t) && (lvl != 0));
            end
            chk("R6 rx count", rx_count, lvl);
            if (lvl < 8) m_push(8'(lvl + 8'h10));
        end
        chk("R6 rx full", {rx_full, rx_empty}, 2'b10);
        m_push(8'hEE);
        chk("R6 push on full ignored", rx_count, 8);
        wr(mk(0, 0, 0, 1, 0, 0, 0, 4));
        chk("R9 rx req disabled", {rx_trig, rx_dma_req}, 2'b10);
        for (int i = 0; i < 8; i++) begin
            chk("R6 rx order", rx_rdata, 8'(i + 8'h10));
            host_pop();
        end
        chk("R6 rx empty", {rx_count, rx_empty}, 5'b0000_1);
        host_pop();
        chk("R6 pop on empty ignored", rx_count, 0);

        // R8 R9: transmit sweep
        for (int lvl = 0; lvl <= 8; lvl++) begin
            for (int t = 0; t < 8; t++) begin
                wr(mk(0, 0, 0, 4, 0, 0, 1, t));
                chk($sformatf("R8 tx trig lvl=%0d thr=%0d", lvl, t), tx_trig, (lvl <= t));
                chk($sformatf("R9 tx req lvl=%0d thr=%0d", lvl, t), tx_dma_req, (lvl <= t));
            end
            if (lvl < 8) host_push(8'(lvl + 8'h40));
        end
        chk("R6 tx full", {tx_full, tx_count}, 5'b1_1000);
        host_push(8'hEE);
        chk("R6 tx push on full ignored", tx_count, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R6 tx order", tx_head, 8'(i + 8'h40));
            tx_pop_eng(1'b0);
        end
        chk("R6 tx empty", tx_empty, 1);

        // R5 assignment
        wr(mk(0, 0, 0, 4, 0, 0, 0, 4));
        s_push(8'hAA);
        chk("R5 slave push ignored", rx_count, 0);
        m_push(8'h11);
        chk("R5 master push taken", rx_count, 1);
        wr(mk(1, 0, 0, 4, 0, 0, 0, 4));
        chk("R2 rx assign readback", reg_rdata, 32'h8004_0004);
        m_push(8'h22);
        chk("R5 master push ignored", rx_count, 1);
        s_push(8'h33);
        chk("R5 slave push taken", rx_count, 2);
        chk("R5 contents kept", rx_rdata, 8'h11);
        host_push(8'h5A);
        tx_pop_eng(1'b1);
        chk("R5 slave tx pop ignored", tx_count, 1);
        wr(mk(1, 0, 0, 4, 1, 0, 0, 4));
        tx_pop_eng(1'b0);
        chk("R5 master tx pop ignored", tx_count, 1);
        tx_pop_eng(1'b1);
        chk("R5 slave tx pop taken", tx_count, 0);

        // R3 R4 flush
        host_push(8'h01);
        host_push(8'h02);
        wr(mk(1, 1, 0, 4, 1, 0, 0, 4));
        chk("R3 rx flush reads 1", reg_rdata[30], 1);
        chk("R4 rx not yet flushed", rx_count, 2);
        s_rx_push = 1'b1; s_rx_data = 8'h99;
        @(negedge clk);
        s_rx_push = 1'b0;
        chk("R4 rx flushed, push dropped", {rx_count, rx_empty}, 5'b0000_1);
        chk("R3 rx flush cleared", reg_rdata[30], 0);
        chk("R4 tx untouched", tx_count, 2);
        wr(mk(1, 0, 0, 4, 1, 1, 0, 4));
        chk("R3 tx flush reads 1", reg_rdata[14], 1);
        tx_push = 1'b1; tx_wdata = 8'h77;
        @(negedge clk);
        tx_push = 1'b0;
        chk("R4 tx flushed, push dropped", {tx_count, tx_empty}, 5'b0000_1);
        chk("R3 tx flush cleared", reg_rdata[14], 0);

        // R1 R2 reserved bits and field readback
        wr(32'hFFFF_FFFF);
        chk("R1 reserved masked with flush", reg_rdata, 32'hE007_E007);
        @(negedge clk);
        chk("R2 fields after self-clear", reg_rdata, 32'hA007_A007);
        wr(32'h0000_0000);
        chk("R2 cleared word", reg_rdata, 32'h0000_0000);
        finish_run();
    end
endmodule